// File: doc/BRIEF.md
# Colour Lookup Register Port

This block holds a colour lookup table of 256 main RGB entries and four overlay entries. The overlay entries are used for cursor colours and sit at lookup indices 256 to 259. A host reaches the table through a small 32-bit register window. It first writes an entry number to the index register. It then streams colour bytes through a data register, one component per access. A phase sequencer records which component is due next: red, then green, then blue. After blue, the sequencer moves to the next entry. Reads from the data register step through the components of the main table in the same way.

Display logic uses a separate lookup port. It presents a 9-bit pixel index and receives the 24-bit RGB of that entry one clock later. If bit 8 of the index is set, the entry comes from the overlay set. Converting the colour to any output pixel format is left to the logic downstream.

Top module: `clut_regport`

## Requirements
- R1: After a synchronous reset, every main entry is black except entry 255, which is white (each component 0xFF). Overlay entries 0 and 2 (lookup 256 and 258) are white, and entries 1 and 3 are black. The index is 0, the phase is red, and `bus_rvalid` and `bus_rdata` are zero.
- R2: A full-word write at byte offset 0 loads the index from `bus_wdata[31:24]` and returns the phase to red, even when a colour is only partly written.
- R3: A full-word write at offset 4 stores `bus_wdata[31:24]` into the current component of main entry `index`. The components are taken in the order red, green, blue, and bits 23:0 of the write are discarded.
- R4: A data access in the blue phase returns the phase to red and increments the index modulo 256, so 255 is followed by 0. Red and green accesses leave the index unchanged.
- R5: A full-word write at offset 12 stores the component into overlay entry `index[1:0]`, seen by the lookup port at 256 + `index[1:0]`. It advances the phase and index as in R4 and leaves the main table unchanged.
- R6: A full-word read at offset 4 returns the current component of main entry `index` in `bus_rdata[31:24]`, with bits 23:0 zero. `bus_rvalid` is high in the cycle after the read, and the read advances the phase and index as in R4.
- R7: In the cycle after `lk_idx` is presented, `lk_rgb` carries red in bits 23:16, green in 15:8 and blue in 7:0. When `lk_idx[8]` is 0 the colour comes from main entry `lk_idx[7:0]`; when it is 1 it comes from overlay entry `lk_idx[1:0]`.
- R8: Any access whose `bus_be` is not 4'hF changes no state. A read of this kind returns zero data, with `bus_rvalid` still high in the following cycle.
- R9: Writes at offsets other than 0, 4 and 12 change no state, and this includes unaligned offsets. Reads at offsets other than 4 also change no state and return zero data. If `bus_wr` and `bus_rd` are high together, the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data; the byte in bits 31:24 is used |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High in the cycle after any read strobe |
| lk_idx | input | 9 | Lookup index; bit 8 selects the overlay set |
| lk_rgb | output | 24 | RGB of the entry presented on the previous cycle |

## Verification
The bench tracks the index, the phase and every stored component itself. Every data read therefore compares the exact component the sequencer should be on. As a result, a phase or index that has slipped shows up at the very next data read as a wrong byte or as a byte taken from the wrong entry. A table entry that was written wrongly, or not cleared by reset, shows up on the lookup port one cycle after its index is presented. After each ignored access the bench makes a data read straight away, so a state change that should not have happened is caught within two cycles.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int OFS_INDEX = 0;
  localparam int OFS_MAIN  = 4;
  localparam int OFS_OVL   = 12;
  localparam int NCOMP     = 3;
endpackage

// File: rtl/clut_seq.sv
// Index register and component phase sequencer.
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= PH_RED;
    end else if (step) begin
      case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/clut_plane.sv
// One colour component of the main table: RAM without reset plus a
// per-entry written flag, so reset takes effect in a single cycle.
module clut_plane #(
  parameter int DEPTH     = 256,
  parameter int DW        = 8,
  parameter bit WHITE_TOP = 1'b1,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DW-1:0]    a_q, b_q;
  logic             a_v, a_top, b_v, b_top;

  // Inferable RAM: one write port and two synchronous read ports.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (ra_en) a_q <= mem[ra_addr];
    b_q <= mem[rb_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      a_v   <= 1'b0;
      a_top <= 1'b0;
      b_v   <= 1'b0;
      b_top <= 1'b0;
    end else begin
      if (we) vld[waddr] <= 1'b1;
      if (ra_en) begin
        a_v   <= vld[ra_addr];
        a_top <= WHITE_TOP && (ra_addr == TOP);
      end
      b_v   <= vld[rb_addr];
      b_top <= WHITE_TOP && (rb_addr == TOP);
    end
  end

  assign ra_data = a_v ? a_q : {DW{a_top}};
  assign rb_data = b_v ? b_q : {DW{b_top}};
endmodule

// File: rtl/clut_overlay.sv
// Small overlay colour set held in flops, with a registered lookup.
module clut_overlay #(
  parameter int N                 = 4,
  parameter int DW                = 8,
  parameter logic [N-1:0] WHITE_MASK = 4'b0101,
  localparam int SW               = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [1:0]    wcomp,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rsel,
  output logic [3*DW-1:0] rgb
);
  logic [2:0][DW-1:0] ent [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        ent[i] <= WHITE_MASK[i] ? '1 : '0;
      end
      rgb <= '0;
    end else begin
      if (we) ent[wsel][wcomp] <= wdata;
      rgb <= {ent[rsel][0], ent[rsel][1], ent[rsel][2]};
    end
  end
endmodule

// File: rtl/clut_regport.sv
module clut_regport
  import clut_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter int DW      = 8,
  parameter int OVL_W   = 2,
  parameter int ADDR_W  = 4,
  parameter int BUS_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W/8-1:0]   bus_be,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic                 bus_rvalid,
  input  logic [ENTRY_W:0]     lk_idx,
  output logic [NCOMP*DW-1:0]  lk_rgb
);
  localparam int DEPTH = 1 << ENTRY_W;
  localparam int NOVL  = 1 << OVL_W;

  logic               full_word;
  logic               wr_idx, wr_main, wr_ovl, rd_main, step;
  logic [DW-1:0]      field;
  logic [ENTRY_W-1:0] seq_idx;
  phase_e             seq_phase;
  logic [DW-1:0]      pa [NCOMP];
  logic [DW-1:0]      pb [NCOMP];
  logic [NCOMP*DW-1:0] ovl_rgb;
  phase_e             rd_sel_q;
  logic               rd_hit_q, lk_ovl_q;
  logic [DW-1:0]      rd_comp;
  logic               unused_wlow;

  assign full_word = &bus_be;
  assign field     = bus_wdata[BUS_W-1 -: DW];
  assign unused_wlow = ^bus_wdata[BUS_W-DW-1:0];

  assign wr_idx  = bus_wr && full_word && (bus_addr == ADDR_W'(OFS_INDEX));
  assign wr_main = bus_wr && full_word && (bus_addr == ADDR_W'(OFS_MAIN));
  assign wr_ovl  = bus_wr && full_word && (bus_addr == ADDR_W'(OFS_OVL));
  assign rd_main = bus_rd && !bus_wr && full_word && (bus_addr == ADDR_W'(OFS_MAIN));
  assign step    = wr_main || wr_ovl || rd_main;

  clut_seq #(.IDX_W(ENTRY_W)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_idx),
    .load_val (field[DW-1 -: ENTRY_W]),
    .step     (step),
    .idx      (seq_idx),
    .phase    (seq_phase)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_plane
    clut_plane #(.DEPTH(DEPTH), .DW(DW), .WHITE_TOP(1'b1)) plane_i (
      .clk     (clk),
      .rst     (rst),
      .we      (wr_main && (seq_phase == phase_e'(c))),
      .waddr   (seq_idx),
      .wdata   (field),
      .ra_en   (rd_main),
      .ra_addr (seq_idx),
      .ra_data (pa[c]),
      .rb_addr (lk_idx[ENTRY_W-1:0]),
      .rb_data (pb[c])
    );
  end

  clut_overlay #(.N(NOVL), .DW(DW), .WHITE_MASK(NOVL'(4'b0101))) ovl_i (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_ovl),
    .wsel  (seq_idx[OVL_W-1:0]),
    .wcomp (seq_phase),
    .wdata (field),
    .rsel  (lk_idx[OVL_W-1:0]),
    .rgb   (ovl_rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q   <= PH_RED;
      rd_hit_q   <= 1'b0;
      bus_rvalid <= 1'b0;
      lk_ovl_q   <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      rd_hit_q   <= rd_main;
      if (rd_main) rd_sel_q <= seq_phase;
      lk_ovl_q   <= lk_idx[ENTRY_W];
    end
  end

  always_comb begin
    case (rd_sel_q)
      PH_RED:  rd_comp = pa[0];
      PH_GRN:  rd_comp = pa[1];
      default: rd_comp = pa[2];
    endcase
  end

  assign bus_rdata = rd_hit_q ? {rd_comp, {(BUS_W-DW){1'b0}}} : '0;
  assign lk_rgb    = lk_ovl_q ? ovl_rgb : {pb[0], pb[1], pb[2]};
endmodule

// File: rtl/clut_regport_chk.sv
module clut_regport_chk #(
  parameter int ENTRY_W = 8,
  parameter int DW      = 8,
  parameter int ADDR_W  = 4,
  parameter int BUS_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BUS_W/8-1:0] bus_be,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic [BUS_W-1:0]   bus_rdata,
  input logic               bus_rvalid,
  input logic [ENTRY_W-1:0] idx,
  input logic [1:0]         phase
);
  logic full, acc_wr_ok, acc_rd_ok, adv, ign, ld;

  assign full      = &bus_be;
  assign acc_wr_ok = full && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(4) ||
                              bus_addr == ADDR_W'(12));
  assign acc_rd_ok = full && (bus_addr == ADDR_W'(4));
  assign ld        = bus_wr && full && (bus_addr == ADDR_W'(0));
  assign adv       = bus_wr ? (full && (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(12)))
                            : (bus_rd && acc_rd_ok);
  assign ign       = bus_wr ? !acc_wr_ok : (bus_rd && !acc_rd_ok);

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);  // R4
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> (phase == 2'd0) && (idx == $past(bus_wdata[BUS_W-1 -: ENTRY_W])));  // R2
  AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && phase == 2'd2) |=> (phase == 2'd0) && (idx == ENTRY_W'($past(idx) + 1'b1)));  // R4
  AST_MID_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && phase != 2'd2) |=> $stable(idx) && (phase == $past(phase) + 2'd1));  // R4
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);  // R6
  AST_RVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);  // R6
  AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (bus_rdata[BUS_W-DW-1:0] == '0));  // R6
  AST_IGNORED_ACCESS: assert property (@(posedge clk) disable iff (rst)
    ign |=> $stable(idx) && $stable(phase));  // R9
  AST_BAD_BE_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && !full) |=> (bus_rdata == '0));  // R8
endmodule

bind clut_regport clut_regport_chk #(
  .ENTRY_W(ENTRY_W), .DW(DW), .ADDR_W(ADDR_W), .BUS_W(BUS_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .idx       (seq_idx),
  .phase     (seq_phase)
);

// File: tb/clut_regport_tb_top.sv
`timescale 1ns/1ps
module clut_regport_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [8:0]  lk_idx = '0;
  logic [23:0] lk_rgb;

  always #2.5 clk = ~clk;

  clut_regport dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  // Reference state
  bit [7:0] mdl [3][256];
  bit [7:0] ovm [3][4];
  bit [7:0] m_idx;
  int       m_ph;
  int       n_cmp = 0;
  int       n_bad = 0;
  bit       finished = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [23:0] exp_rgb(logic [8:0] i);
    if (i[8]) return {ovm[0][i[1:0]], ovm[1][i[1:0]], ovm[2][i[1:0]]};
    return {mdl[0][i[7:0]], mdl[1][i[7:0]], mdl[2][i[7:0]]};
  endfunction

  function automatic void adv();
    if (m_ph == 2) begin
      m_ph = 0;
      m_idx = m_idx + 8'd1;
    end else begin
      m_ph = m_ph + 1;
    end
  endfunction

  task automatic do_wr(logic [3:0] a, logic [3:0] be, logic [31:0] d);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(logic [3:0] a, logic [3:0] be, logic [31:0] exp, string req);
    bus_addr = a; bus_be = be; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk({req, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
    chk({req, " rdata"}, bus_rdata, exp);
  endtask

  task automatic set_idx(logic [7:0] v);
    do_wr(4'd0, 4'hF, {v, 24'($urandom)});
    m_idx = v; m_ph = 0;
  endtask

  task automatic wr_main(logic [7:0] v);
    do_wr(4'd4, 4'hF, {v, 24'($urandom)});
    mdl[m_ph][m_idx] = v; adv();
  endtask

  task automatic wr_ovl(logic [7:0] v);
    do_wr(4'd12, 4'hF, {v, 24'($urandom)});
    ovm[m_ph][m_idx[1:0]] = v; adv();
  endtask

  task automatic rd_data(string req);
    logic [31:0] e;
    e = {mdl[m_ph][m_idx], 24'h0};
    do_rd(4'd4, 4'hF, e, req);
    adv();
  endtask

  task automatic look(logic [8:0] i, string req);
    lk_idx = i;
    @(negedge clk);
    chk(req, {8'h0, lk_rgb}, {8'h0, exp_rgb(i)});
  endtask

  function automatic logic [3:0] bad_wr_ofs();
    logic [3:0] a;
    do a = 4'($urandom); while (a == 4'd0 || a == 4'd4 || a == 4'd12);
    return a;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int e = 0; e < 256; e++)
      for (int c = 0; c < 3; c++) mdl[c][e] = (e == 255) ? 8'hFF : 8'h00;
    for (int o = 0; o < 4; o++)
      for (int c = 0; c < 3; c++) ovm[c][o] = (o == 0 || o == 2) ? 8'hFF : 8'h00;
    m_idx = 0; m_ph = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs and contents after reset
    chk("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    for (int i = 0; i < 260; i++) look(9'(i), "R1 lookup");
    rd_data("R1 first read");

    // R6/R4: read white entry 255 then wrap to 0
    set_idx(8'hFF);
    rd_data("R6 red"); rd_data("R6 green"); rd_data("R6 blue");
    rd_data("R4 wrap read");

    // R3: three components into one entry
    set_idx(8'h10);
    wr_main(8'h11); wr_main(8'h22); wr_main(8'h33);
    look(9'h010, "R3 entry");
    look(9'h011, "R3 neighbour");

    // R4: write wrap from 255 to 0
    set_idx(8'hFF);
    wr_main(8'hA1); wr_main(8'hA2); wr_main(8'hA3); wr_main(8'h5C);
    look(9'h0FF, "R4 entry255");
    look(9'h000, "R4 wrap entry0");

    // R5: overlay via low 2 bits of index
    set_idx(8'h06);
    wr_ovl(8'h12); wr_ovl(8'h34); wr_ovl(8'h56);
    look(9'h102, "R5 overlay2");
    look(9'h006, "R5 main untouched");
    wr_ovl(8'h77);
    look(9'h103, "R5 overlay3");
    rd_data("R5 phase after overlay");

    // R2: index reload mid colour resets phase to red
    set_idx(8'h20);
    wr_main(8'h01);
    set_idx(8'h21);
    wr_main(8'h05);
    look(9'h020, "R2 partial");
    look(9'h021, "R2 reload");

    // R8: bad byte enables
    set_idx(8'h30);
    do_wr(4'd4, 4'h7, 32'hEE00_0000);
    look(9'h030, "R8 write ignored");
    do_rd(4'd4, 4'hE, 32'd0, "R8 read ignored");
    rd_data("R8 state kept");

    // R9: bad offsets
    do_wr(4'd8, 4'hF, 32'hDD00_0000);
    do_wr(4'd2, 4'hF, 32'hDD00_0000);
    do_rd(4'd0, 4'hF, 32'd0, "R9 read other offset");
    rd_data("R9 state kept");
    look(9'h030, "R9 table kept");

    // R7: alias of high indices onto overlay
    look(9'h1FE, "R7 alias");
    look(9'h1FF, "R7 alias");

    // Random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom_range(0, 7));
      case (op)
        0: set_idx(($urandom_range(0, 3) == 0) ? 8'($urandom_range(252, 255)) : 8'($urandom));
        1, 2: wr_main(8'($urandom));
        3: wr_ovl(8'($urandom));
        4: rd_data("R6 random read");
        5: begin
          logic [3:0] be;
          be = 4'($urandom_range(0, 14));
          if ($urandom_range(0, 1) == 0) do_wr(4'd4, be, $urandom);
          else do_rd(4'd4, be, 32'd0, "R8 random bad be");
          rd_data("R8 random state");
        end
        6: begin
          if ($urandom_range(0, 1) == 0) do_wr(bad_wr_ofs(), 4'hF, $urandom);
          else begin
            logic [3:0] a;
            do a = 4'($urandom); while (a == 4'd4);
            do_rd(a, 4'hF, 32'd0, "R9 random bad read");
          end
          rd_data("R9 random state");
        end
        default: look(9'($urandom), "R7 random lookup");
      endcase
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule